// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns simple read and write commands into bus cycles on a processor-side bus. The bus has a 20-bit address and a 16-bit data path, and the low 16 address bits share their lines with the data. A requester offers one command at a time: memory or I/O space, read or write, an address, write data and two byte-lane enables. The block accepts the command only while it is idle. It then runs the cycle through the states T1, T2, T3, any number of wait states Tw, and T4, and reports completion with a one-cycle response pulse that carries the read data.

In T1 the shared lines and the four upper lines carry the address, together with an active-high address latch strobe. The upper lines and the high-byte enable then switch to status. Active-low read and write strobes and an active-low transceiver enable frame the data phase. A direction output and a memory/I/O select stay steady for the whole cycle. A slow target stretches the cycle by pulling `ready` low. The shared lines are split into `ad_out`, `ad_oe` and `ad_in`, so that a pad cell outside the block can merge them.

Top module: `mux_bus_seq`

## Requirements
- R1: A command is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle. The cycle after acceptance is T1, and no command is taken until the sequence has returned to idle after T4.
- R2: In T1, `ale`=1, `ad_oe`=1, `ad_out`=address[15:0], `as_out`=address[19:16] and `bhe_n` = NOT byte-enable bit 1. `ale` is 0 in every other state.
- R3: From T2 through T4, `as_out` = {2'b00, memory flag, write flag} and `bhe_n`=1.
- R4: From T1 through T4, `m_io` is 1 for memory space and 0 for I/O space. `dt_r` is 1 for writes and 0 for reads.
- R5: `rd_n` (reads) or `wr_n` (writes) is 0 in T2, T3 and every Tw, and 1 in T1 and T4. `den_n` is 0 in exactly those same states.
- R6: For a write, `ad_oe`=1 from T2 through T4, and `ad_out` carries the write data with every byte lane whose enable bit is 0 forced to zero (bit 0 enables bits 7:0, bit 1 enables bits 15:8). For a read, `ad_oe`=0 from T2 through T4. `ad_out` is zero whenever `ad_oe` is 0.
- R7: `ready` is sampled only at the end of T3 and at the end of each Tw. Every low sample adds one Tw, and the first high sample moves to T4. `ready` has no effect in T1 or T2.
- R8: `rsp_valid` is high for exactly one cycle, during T4, for every command. For a read, `rsp_rdata` holds `ad_in` as sampled at the end of the final T3 or Tw, with byte lanes whose enable is 0 replaced by zero.
- R9: While `rst_n` is low, the outputs take their idle values at once, aborting any cycle in progress. The idle values are `ale`=0, `ad_oe`=0, `ad_out`=0, `as_out`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `dt_r`=0, `m_io`=0, `rsp_valid`=0 and `req_ready`=1. The first command after release starts with a fresh T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Sequencer idle and able to take a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables; bit 1 = high byte |
| rsp_valid | output | 1 | Command completed (T4) |
| rsp_rdata | output | 16 | Read data of the completed command |
| ad_out | output | 16 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared lines as seen at the pads |
| as_out | output | 4 | Upper address in T1, status afterwards |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = outbound |
| bhe_n | output | 1 | High-byte enable in T1, status afterwards |
| ready | input | 1 | Target ready; low requests wait states |

## Verification
The bench pulls `ready` low during T1 and T2 when it also asks for wait states. A design that sampled `ready` too early would stall or shorten the cycle and misplace T4. During the early wait states the target model drives junk on `ad_in` and puts the real word there only in the final state. A design that captured data one state too soon, or at T4, would return the junk. Cycles with only the low or only the high lane enabled would show a wrong high-byte enable or unmasked data. A reset asserted during a wait state checks that a design which held its strobes, or resumed the stale cycle, is caught.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;
endpackage

// File: rtl/mbs_cmd_reg.sv
module mbs_cmd_reg #(
  parameter int DATA_W = 16,
  parameter int HI_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   in_write,
  input  logic                   in_mem,
  input  logic [DATA_W+HI_W-1:0] in_addr,
  input  logic [DATA_W-1:0]      in_wdata,
  input  logic [DATA_W/8-1:0]    in_be,
  output logic                   cmd_write,
  output logic                   cmd_mem,
  output logic [DATA_W+HI_W-1:0] cmd_addr,
  output logic [DATA_W-1:0]      cmd_wdata,
  output logic [DATA_W/8-1:0]    cmd_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_write <= 1'b0;
      cmd_mem   <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      cmd_be    <= '0;
    end else if (load) begin
      cmd_write <= in_write;
      cmd_mem   <= in_mem;
      cmd_addr  <= in_addr;
      cmd_wdata <= in_wdata;
      cmd_be    <= in_be;
    end
  end
endmodule

// File: rtl/mbs_phase_fsm.sv
module mbs_phase_fsm
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   ready,
  output phase_t phase,
  output logic   accept
);
  phase_t phase_nxt;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE: if (req_valid) phase_nxt = PH_T1;
      PH_T1:   phase_nxt = PH_T2;
      PH_T2:   phase_nxt = PH_T3;
      PH_T3,
      PH_TW:   phase_nxt = ready ? PH_T4 : PH_TW;
      PH_T4:   phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  assign accept = (phase == PH_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HI_W   = 4
) (
  input  phase_t                 phase,
  input  logic                   cmd_write,
  input  logic                   cmd_mem,
  input  logic [DATA_W+HI_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]      cmd_wdata,
  input  logic [DATA_W/8-1:0]    cmd_be,
  output logic [DATA_W-1:0]      ad_out,
  output logic                   ad_oe,
  output logic [HI_W-1:0]        as_out,
  output logic                   ale,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   m_io,
  output logic                   den_n,
  output logic                   dt_r,
  output logic                   bhe_n
);
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] wdata_lanes;
  logic [HI_W-1:0]   status;
  logic              strobe_on;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign wdata_lanes[g*8 +: 8] = cmd_be[g] ? cmd_wdata[g*8 +: 8] : 8'h00;
  end

  assign status    = {{(HI_W-2){1'b0}}, cmd_mem, cmd_write};
  assign strobe_on = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    as_out = '0;
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    den_n  = 1'b1;
    m_io   = 1'b0;
    dt_r   = 1'b0;
    bhe_n  = 1'b1;
    if (phase != PH_IDLE) begin
      m_io = cmd_mem;
      dt_r = cmd_write;
      if (phase == PH_T1) begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = cmd_addr[DATA_W-1:0];
        as_out = cmd_addr[DATA_W+HI_W-1:DATA_W];
        bhe_n  = ~cmd_be[BE_W-1];
      end else begin
        as_out = status;
        if (cmd_write) begin
          ad_oe  = 1'b1;
          ad_out = wdata_lanes;
        end
        rd_n  = ~(strobe_on & ~cmd_write);
        wr_n  = ~(strobe_on & cmd_write);
        den_n = ~strobe_on;
      end
    end
  end
endmodule

// File: rtl/mbs_rdata_cap.sv
module mbs_rdata_cap
  import mbs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_t              phase,
  input  logic                ready,
  input  logic                cmd_write,
  input  logic [DATA_W/8-1:0] cmd_be,
  input  logic [DATA_W-1:0]   ad_in,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata
);
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] lanes;
  logic              last_wait;
  logic              cap_en;
  logic              valid_nxt;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lanes[g*8 +: 8] = cmd_be[g] ? ad_in[g*8 +: 8] : 8'h00;
  end

  assign last_wait = ((phase == PH_T3) || (phase == PH_TW)) && ready;
  assign cap_en    = last_wait && !cmd_write;
  assign valid_nxt = last_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (cap_en) rsp_rdata <= lanes;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HI_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_mem,
  input  logic [DATA_W+HI_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [DATA_W-1:0]      ad_out,
  output logic                   ad_oe,
  input  logic [DATA_W-1:0]      ad_in,
  output logic [HI_W-1:0]        as_out,
  output logic                   ale,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   m_io,
  output logic                   den_n,
  output logic                   dt_r,
  output logic                   bhe_n,
  input  logic                   ready
);
  localparam int ADDR_W = DATA_W + HI_W;
  localparam int BE_W   = DATA_W / 8;

  phase_t            phase;
  logic              accept;
  logic              cmd_write;
  logic              cmd_mem;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata;
  logic [BE_W-1:0]   cmd_be;

  assign req_ready = (phase == PH_IDLE);

  mbs_phase_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .phase     (phase),
    .accept    (accept)
  );

  mbs_cmd_reg #(.DATA_W(DATA_W), .HI_W(HI_W)) i_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .in_write  (req_write),
    .in_mem    (req_mem),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .in_be     (req_be),
    .cmd_write (cmd_write),
    .cmd_mem   (cmd_mem),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_be    (cmd_be)
  );

  mbs_pin_drive #(.DATA_W(DATA_W), .HI_W(HI_W)) i_pins (
    .phase     (phase),
    .cmd_write (cmd_write),
    .cmd_mem   (cmd_mem),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_be    (cmd_be),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .as_out    (as_out),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .m_io      (m_io),
    .den_n     (den_n),
    .dt_r      (dt_r),
    .bhe_n     (bhe_n)
  );

  mbs_rdata_cap #(.DATA_W(DATA_W)) i_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .ready     (ready),
    .cmd_write (cmd_write),
    .cmd_be    (cmd_be),
    .ad_in     (ad_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic ad_oe,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic dt_r,
  input logic ready,
  input logic rsp_valid
);
  assert_accept_t1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_dir_vs_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> (dt_r == !wr_n));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_read_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_rd_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !ready) |=> !rd_n);

  assert_wr_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !ready) |=> !wr_n);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R9: assert (rd_n && wr_n && den_n && !ale && !ad_oe);
    end
  end
endmodule

bind mux_bus_seq mbs_checker i_mbs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ale       (ale),
  .ad_oe     (ad_oe),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .den_n     (den_n),
  .dt_r      (dt_r),
  .ready     (ready),
  .rsp_valid (rsp_valid)
);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic        req_mem;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in;
  logic [3:0]  as_out;
  logic        ale;
  logic        rd_n;
  logic        wr_n;
  logic        m_io;
  logic        den_n;
  logic        dt_r;
  logic        bhe_n;
  logic        ready;

  int checks;
  int fails;
  bit done;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mem(req_mem), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .as_out(as_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io),
    .den_n(den_n), .dt_r(dt_r), .bhe_n(bhe_n), .ready(ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req_ready, rsp_valid, ale, ad_oe, ad_out, as_out, rd_n, wr_n, den_n, dt_r, m_io, bhe_n}
  function automatic logic [29:0] pins();
    return {req_ready, rsp_valid, ale, ad_oe, ad_out, as_out,
            rd_n, wr_n, den_n, dt_r, m_io, bhe_n};
  endfunction

  localparam logic [29:0] IDLE_PINS = {1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 4'h0,
                                       1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic check(input string tag, input logic [29:0] got, input logic [29:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
  endfunction

  // Runs one command; the target holds ready low for `waits` samples.
  task automatic run_cycle(input string name, input logic wr, input logic mem,
                           input logic [19:0] addr, input logic [15:0] wd,
                           input logic [1:0] be, input int waits);
    logic [15:0] good_rd;
    good_rd = addr[15:0] ^ 16'hA5C3;
    @(negedge clk);
    check({name, " R1 idle before accept"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_mem = mem;
    req_addr = addr; req_wdata = wd; req_be = be;
    for (int p = 0; p <= 3 + waits; p++) begin
      logic strobe;
      logic [29:0] exp;
      @(negedge clk);
      req_valid = 1'b0;
      strobe = (p >= 1) && (p <= 2 + waits);
      exp = {1'b0,                                   // R1 busy
             (p == 3 + waits),                       // R8
             (p == 0),                               // R2
             (p == 0) || wr,                         // R6
             (p == 0) ? addr[15:0] : (wr ? lanes(wd, be) : 16'h0),
             (p == 0) ? addr[19:16] : {2'b00, mem, wr}, // R3
             !(strobe && !wr), !(strobe && wr), !strobe,  // R5
             wr, mem,                                // R4
             (p == 0) ? !be[1] : 1'b1};
      check($sformatf("%s R2 R3 R4 R5 R6 R7 phase %0d", name, p), pins(), exp);
      if (p == 3 + waits && !wr)
        check({name, " R8 read data"}, {14'd0, rsp_rdata}, {14'd0, lanes(good_rd, be)});
      // ready for the sample at the end of this state (R7: ignored in T1/T2)
      ready = (p < 2) ? (waits == 0) : (p >= 2 + waits);
      ad_in = (p == 2 + waits) ? good_rd : (16'hDEAD ^ 16'(p));
    end
    @(negedge clk);
    ready = 1'b1;
    check({name, " R1 R9 back to idle"}, pins(), IDLE_PINS);
  endtask

  task automatic reset_abort();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b1;
    req_addr = 20'h3_1234; req_be = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    ready = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 still waiting", {29'd0, rd_n}, 30'd0);
    rst_n = 1'b0;
    #1;
    check("R9 abort outputs", pins(), IDLE_PINS);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    ready = 1'b1;
    @(negedge clk);
    check("R9 idle after release", pins(), IDLE_PINS);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_mem = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0; ad_in = '0; ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 reset state", pins(), IDLE_PINS);
    rst_n = 1'b1;
    run_cycle("mem read 0w",  1'b0, 1'b1, 20'hA_BCDE, 16'h0000, 2'b11, 0);
    run_cycle("mem write 2w", 1'b1, 1'b1, 20'h5_0F0F, 16'h1357, 2'b11, 2);
    run_cycle("io read lo 3w", 1'b0, 1'b0, 20'h0_0042, 16'h0000, 2'b01, 3);
    run_cycle("io write hi 1w", 1'b1, 1'b0, 20'h0_8001, 16'hBEEF, 2'b10, 1);
    run_cycle("mem read hi 4w", 1'b0, 1'b1, 20'hF_FFFE, 16'h0000, 2'b10, 4);
    reset_abort();
    run_cycle("mem write after reset", 1'b1, 1'b1, 20'h7_2468, 16'hC0DE, 2'b11, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule